// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block moves 16-bit words between a processor core and its stack in memory over a byte-wide bus. It is given one request at a time: save a word (push), restore a word (pop), save a return address for a subroutine entry (call), or restore one on subroutine exit (return). The return request comes with a condition flag. The core decodes the instruction and evaluates the condition. The sequencer then produces the address, write data and write strobe for each machine cycle. It assembles restored words and reports the updated stack pointer. It pulses a done strobe in the last cycle of each transfer. A restart instruction is handled as a call whose target is fixed by the opcode. For this block, that case is identical to a call.

Timing is counted in clock cycles. Cycle 1 is the clock period that follows the rising edge that samples the request. Requests are sampled only while the block is idle, and `sp_in`, `push_word` and `ret_cond` are captured at that same edge. The memory is a synchronous single-port byte array. Its read data appears in the cycle after the address is presented. `mem_addr` always shows the working stack pointer, and a write happens at that address whenever `mem_we` is high.

Top module: `stk_seq`

## Requirements
- R1: A push or call produces exactly two write cycles, back to back: first the high byte of the word at SP-1, then the low byte at SP-2, where SP is the sampled `sp_in`.
- R2: A push raises `done` in cycle 4, writes in cycles 2 and 3, and shows `sp_out` = SP-2 in the done cycle.
- R3: A pop reads address SP (low byte) then SP+1 (high byte), raises `done` in cycle 3 with `pop_word` = {mem[SP+1], mem[SP]}, and shows `sp_out` = SP+2.
- R4: A return with `ret_cond`=1 raises `done` in cycle 5, with the same word and stack pointer result as a pop.
- R5: A return with `ret_cond`=0 raises `done` in cycle 2, writes nothing, leaves `sp_out` equal to SP, and leaves `pop_word` at its previous value.
- R6: A call raises `done` in cycle 6, writes in cycles 4 and 5, and shows `sp_out` = SP-2.
- R7: `done` is high for exactly one clock per transfer, `busy` is high from cycle 1 through the done cycle, and `busy` is low in the cycle after.
- R8: Requests that arrive while `busy` is high are ignored and leave no pending transfer behind.
- R9: When several requests are raised together, one transfer runs, chosen with priority call, then push, then pop, then return.
- R10: While reset is asserted, `busy`, `done` and `mem_we` are 0, and `sp_out` and `pop_word` are 0.
- R11: `mem_we` is never high while idle.
- R12: Stack pointer arithmetic wraps modulo 2^16. A push at SP=0x0001 writes 0x0000 and 0xFFFF, and a pop at SP=0xFFFF reads 0xFFFF and 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_push | input | 1 | Start a push |
| req_pop | input | 1 | Start a pop |
| req_call | input | 1 | Start a call (return address save) |
| req_ret | input | 1 | Start a conditional return |
| ret_cond | input | 1 | Condition result for a return, sampled with the request |
| push_word | input | 16 | Word to save on push or call |
| sp_in | input | 16 | Stack pointer at the start of the transfer |
| mem_rdata | input | 8 | Read data from the byte memory, one cycle after the address |
| mem_addr | output | 16 | Byte address for the current cycle |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| pop_word | output | 16 | Word restored by a pop or a taken return |
| sp_out | output | 16 | Updated stack pointer |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock strobe in the last cycle of a transfer |

## Verification
The bench targets byte order and address order. A design that swaps the two write bytes, or that decrements the pointer after a write instead of before it, leaves the word one slot off or byte-reversed, and the following pop does not return it. The taken and not-taken return paths are timed separately: a design that skips the condition, or that reads memory on the not-taken path, finishes in the wrong cycle or disturbs `pop_word` and `sp_out`. The bench also raises requests while a transfer is running and raises several requests at once. A design with a missing idle guard or a wrong priority starts a second transfer or runs the wrong one, which changes the cycle count. Transfers that cross address 0x0000 check the modular pointer arithmetic.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_WAIT  = 4'd1,
    ST_DEC   = 4'd2,
    ST_WR_HI = 4'd3,
    ST_WR_LO = 4'd4,
    ST_RD_LO = 4'd5,
    ST_RD_HI = 4'd6,
    ST_GAP   = 4'd7,
    ST_CHK   = 4'd8,
    ST_FIN   = 4'd9
  } stk_st_e;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int CALL_WAIT = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_push,
  input  logic    req_pop,
  input  logic    req_call,
  input  logic    req_ret,
  input  logic    cond,
  output stk_op_e op,
  output logic    ld,
  output logic    sp_dec,
  output logic    sp_inc,
  output logic    wr_hi,
  output logic    wr_lo,
  output logic    rd_lo,
  output logic    rd_hi,
  output logic    busy,
  output logic    done
);

  localparam int WCW = (CALL_WAIT > 1) ? $clog2(CALL_WAIT) : 1;

  stk_st_e st_q, st_d;
  stk_op_e op_q, op_d;
  logic    cond_q, cond_d;
  logic    any_req;
  logic    wait_last;
  stk_op_e sel_op;

  // Wait slots of a call are only built when the parameter asks for them
  generate
    if (CALL_WAIT > 0) begin : g_wait
      logic [WCW-1:0] wcnt_q, wcnt_d;
      always_comb begin
        if (st_q == ST_WAIT) wcnt_d = WCW'(wcnt_q + 1'b1);
        else                 wcnt_d = '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wcnt_q <= '0;
        else        wcnt_q <= wcnt_d;
      end
      assign wait_last = (wcnt_q == WCW'(CALL_WAIT - 1));
    end else begin : g_nowait
      assign wait_last = 1'b1;
    end
  endgenerate

  // Fixed priority among simultaneous requests: call, push, pop, return
  always_comb begin
    any_req = req_call | req_push | req_pop | req_ret;
    if (req_call)      sel_op = OP_CALL;
    else if (req_push) sel_op = OP_PUSH;
    else if (req_pop)  sel_op = OP_POP;
    else               sel_op = OP_RET;
  end

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    cond_d = cond_q;
    ld     = 1'b0;
    sp_dec = 1'b0;
    sp_inc = 1'b0;
    wr_hi  = 1'b0;
    wr_lo  = 1'b0;
    rd_lo  = 1'b0;
    rd_hi  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (any_req) begin
          ld     = 1'b1;
          op_d   = sel_op;
          cond_d = cond;
          unique case (sel_op)
            OP_PUSH: st_d = ST_DEC;
            OP_POP:  st_d = ST_RD_LO;
            OP_CALL: st_d = (CALL_WAIT > 0) ? ST_WAIT : ST_DEC;
            OP_RET:  st_d = ST_CHK;
            default: st_d = ST_IDLE;
          endcase
        end
      end
      ST_WAIT: begin
        if (wait_last) st_d = ST_DEC;
      end
      ST_DEC: begin
        sp_dec = 1'b1;
        st_d   = ST_WR_HI;
      end
      ST_WR_HI: begin
        wr_hi  = 1'b1;
        sp_dec = 1'b1;
        st_d   = ST_WR_LO;
      end
      ST_WR_LO: begin
        wr_lo = 1'b1;
        st_d  = ST_FIN;
      end
      ST_RD_LO: begin
        rd_lo  = 1'b1;
        sp_inc = 1'b1;
        st_d   = ST_RD_HI;
      end
      ST_RD_HI: begin
        rd_hi  = 1'b1;
        sp_inc = 1'b1;
        st_d   = (op_q == OP_RET) ? ST_GAP : ST_FIN;
      end
      ST_GAP: st_d = ST_FIN;
      ST_CHK: st_d = cond_q ? ST_RD_LO : ST_FIN;
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_PUSH;
      cond_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ld) begin
        op_q   <= op_d;
        cond_q <= cond_d;
      end
    end
  end

  assign op   = op_q;
  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_FIN);

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              dec,
  input  logic              inc,
  input  logic [ADDR_W-1:0] sp_in,
  output logic [ADDR_W-1:0] sp
);

  logic [ADDR_W-1:0] sp_q, sp_d;
  logic              sp_en;

  always_comb begin
    sp_en = ld | dec | inc;
    if (ld)       sp_d = sp_in;
    else if (dec) sp_d = sp_q - ADDR_W'(1);
    else          sp_d = sp_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

endmodule

// File: rtl/stk_data.sv
module stk_data #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic                rd_lo,
  input  logic                rd_hi,
  input  logic [2*BYTE_W-1:0] push_word,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic [2*BYTE_W-1:0] pop_word
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] pw_q;
  logic [WORD_W-1:0] word_q;
  logic [BYTE_W-1:0] lo_q;
  logic              lo_pend_q;
  logic              hi_pend_q;
  logic [WORD_W-1:0] word_live;

  // Read data trails the address by one cycle; the pend flags mark its arrival
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_pend_q <= 1'b0;
      hi_pend_q <= 1'b0;
    end else begin
      lo_pend_q <= rd_lo;
      hi_pend_q <= rd_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pw_q <= '0;
    else if (ld) pw_q <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lo_q <= '0;
    else if (lo_pend_q) lo_q <= mem_rdata;
  end

  assign word_live = {mem_rdata, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (hi_pend_q) word_q <= word_live;
  end

  // Bypass lets a pop finish in the cycle the high byte arrives
  assign pop_word = hi_pend_q ? word_live : word_q;

  always_comb begin
    if (wr_hi)      mem_wdata = pw_q[WORD_W-1:BYTE_W];
    else if (wr_lo) mem_wdata = pw_q[BYTE_W-1:0];
    else            mem_wdata = '0;
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int CALL_WAIT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_push,
  input  logic                req_pop,
  input  logic                req_call,
  input  logic                req_ret,
  input  logic                ret_cond,
  input  logic [2*BYTE_W-1:0] push_word,
  input  logic [ADDR_W-1:0]   sp_in,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic [2*BYTE_W-1:0] pop_word,
  output logic [ADDR_W-1:0]   sp_out,
  output logic                busy,
  output logic                done
);

  stk_op_e           op_q;
  logic              ld, sp_dec, sp_inc;
  logic              wr_hi, wr_lo, rd_lo, rd_hi;
  logic [ADDR_W-1:0] sp_q;

  stk_ctrl #(.CALL_WAIT(CALL_WAIT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_push (req_push),
    .req_pop  (req_pop),
    .req_call (req_call),
    .req_ret  (req_ret),
    .cond     (ret_cond),
    .op       (op_q),
    .ld       (ld),
    .sp_dec   (sp_dec),
    .sp_inc   (sp_inc),
    .wr_hi    (wr_hi),
    .wr_lo    (wr_lo),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .busy     (busy),
    .done     (done)
  );

  stk_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ld),
    .dec   (sp_dec),
    .inc   (sp_inc),
    .sp_in (sp_in),
    .sp    (sp_q)
  );

  stk_data #(.BYTE_W(BYTE_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (ld),
    .wr_hi     (wr_hi),
    .wr_lo     (wr_lo),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .push_word (push_word),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .pop_word  (pop_word)
  );

  // The working pointer addresses every access: pre-decrement on writes,
  // post-increment on reads
  assign mem_addr = sp_q;
  assign mem_we   = wr_hi | wr_lo;
  assign sp_out   = sp_q;

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk
  import stk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] sp_out,
  input stk_op_e           op
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_write_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |=> mem_we && (mem_addr == ADDR_W'($past(mem_addr) - 1)));

  assert_write_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |=> !mem_we);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  assert_push_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_PUSH) |-> sp_out == ADDR_W'($past(sp_out, 3) - 2));

  assert_pop_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_POP) |-> sp_out == ADDR_W'($past(sp_out, 2) + 2));

  assert_call_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_CALL) |-> sp_out == ADDR_W'($past(sp_out, 5) - 2));

endmodule

bind stk_seq stk_seq_chk #(.ADDR_W(ADDR_W)) u_stk_seq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .sp_out   (sp_out),
  .op       (op_q)
);

// File: tb/test_stk_seq.sv
module test_stk_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = 4'b0000;   // bit0 push, bit1 pop, bit2 call, bit3 return
  logic        ret_cond = 1'b0;
  logic [15:0] push_word = '0;
  logic [15:0] sp_in = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [15:0] pop_word;
  logic [15:0] sp_out;
  logic        busy;
  logic        done;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  stk_seq i_stk_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_push  (req[0]),
    .req_pop   (req[1]),
    .req_call  (req[2]),
    .req_ret   (req[3]),
    .ret_cond  (ret_cond),
    .push_word (push_word),
    .sp_in     (sp_in),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .pop_word  (pop_word),
    .sp_out    (sp_out),
    .busy      (busy),
    .done      (done)
  );

  // Byte memory model, synchronous read, indexed by the low address byte
  logic [7:0] mem [256];
  logic       pl_en = 1'b0;
  logic [7:0] pl_a = '0;
  logic [7:0] pl_d = '0;
  always @(posedge clk) begin
    if (pl_en)       mem[pl_a] <= pl_d;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_a = a; pl_d = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  // Runs one transfer; samples mid-cycle, cycle 1 follows the request edge
  task automatic run_op(input logic [3:0] r, input logic c,
                        input logic [15:0] sp, input logic [15:0] d,
                        input logic [3:0] inj,
                        output int ncyc, output int nw,
                        output logic [15:0] wa0, output logic [15:0] wa1,
                        output logic [7:0] wd0, output logic [7:0] wd1,
                        output int wc0, output int wc1);
    @(negedge clk);
    req = r; ret_cond = c; sp_in = sp; push_word = d;
    @(negedge clk);
    req = 4'b0000;
    ncyc = 0; nw = 0; wa0 = '0; wa1 = '0; wd0 = '0; wd1 = '0; wc0 = 0; wc1 = 0;
    for (int k = 1; k <= 20; k++) begin
      if (k == 2) req = inj;
      if (k == 3) req = 4'b0000;
      if (mem_we) begin
        if (nw == 0) begin wa0 = mem_addr; wd0 = mem_wdata; wc0 = k; end
        else         begin wa1 = mem_addr; wd1 = mem_wdata; wc1 = k; end
        nw++;
      end
      if (done) begin ncyc = k; break; end
      @(negedge clk);
    end
    req = 4'b0000;
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        cond;
    logic [15:0] sp;
    logic [15:0] data;
    logic [3:0]  cyc;
    logic [15:0] sp_exp;
    logic [15:0] word_exp;
    logic        is_write;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'b0001, 1'b0, 16'h0080, 16'hA1B2, 4'd4, 16'h007E, 16'h0000, 1'b1}, // R2 push
    '{4'b0010, 1'b0, 16'h007E, 16'h0000, 4'd3, 16'h0080, 16'hA1B2, 1'b0}, // R3 pop
    '{4'b0100, 1'b0, 16'h0060, 16'h1234, 4'd6, 16'h005E, 16'h0000, 1'b1}, // R6 call
    '{4'b1000, 1'b1, 16'h005E, 16'h0000, 4'd5, 16'h0060, 16'h1234, 1'b0}, // R4 taken
    '{4'b1000, 1'b0, 16'h0040, 16'h0000, 4'd2, 16'h0040, 16'h1234, 1'b0}, // R5 not taken
    '{4'b0001, 1'b0, 16'h0001, 16'hC3D4, 4'd4, 16'hFFFF, 16'h0000, 1'b1}, // R12 wrap push
    '{4'b0010, 1'b0, 16'hFFFF, 16'h0000, 4'd3, 16'h0001, 16'hC3D4, 1'b0}, // R12 wrap pop
    '{4'b0010, 1'b0, 16'h0090, 16'h0000, 4'd3, 16'h0092, 16'h6B5A, 1'b0}  // R3 preloaded
  };

  task automatic check_writes(input string tag, input logic [15:0] sp,
                              input logic [15:0] d, input int ncyc, input int nw,
                              input logic [15:0] wa0, input logic [15:0] wa1,
                              input logic [7:0] wd0, input logic [7:0] wd1,
                              input int wc0, input int wc1);
    // R1: high byte at SP-1, then low byte at SP-2, in the two cycles before done
    check(nw == 2, tag, "R1 write count", nw, 2);
    check(wa0 == 16'(sp - 16'd1) && wd0 == d[15:8], tag, "R1 first write addr/data",
          {wa0, 8'h00, wd0}, {16'(sp - 16'd1), 8'h00, d[15:8]});
    check(wa1 == 16'(sp - 16'd2) && wd1 == d[7:0], tag, "R1 second write addr/data",
          {wa1, 8'h00, wd1}, {16'(sp - 16'd2), 8'h00, d[7:0]});
    check(wc0 == ncyc - 2 && wc1 == ncyc - 1, tag, "write cycles",
          32'(wc0 * 16 + wc1), 32'((ncyc - 2) * 16 + ncyc - 1));
  endtask

  initial begin
    int ncyc, nw, wc0, wc1;
    logic [15:0] wa0, wa1;
    logic [7:0]  wd0, wd1;
    string tag;

    // R10: reset values
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_we, "R10", "busy/done/we in reset",
          {busy, done, mem_we}, 3'b000);
    check(sp_out == 16'h0 && pop_word == 16'h0, "R10", "sp_out/pop_word in reset",
          {sp_out, pop_word}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    preload(8'h90, 8'h5A);
    preload(8'h91, 8'h6B);

    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VECS[i];
      if (i == 5 || i == 6)  tag = "R12";
      else if (v.req[0])     tag = "R2";
      else if (v.req[1])     tag = "R3";
      else if (v.req[2])     tag = "R6";
      else if (v.cond)       tag = "R4";
      else                   tag = "R5";
      run_op(v.req, v.cond, v.sp, v.data, 4'b0000, ncyc, nw, wa0, wa1, wd0, wd1, wc0, wc1);
      check(ncyc == int'(v.cyc), tag, "done cycle", ncyc, v.cyc);
      check(sp_out == v.sp_exp, tag, "sp_out at done", sp_out, v.sp_exp);
      if (v.is_write) begin
        check_writes(tag, v.sp, v.data, ncyc, nw, wa0, wa1, wd0, wd1, wc0, wc1);
      end else begin
        check(pop_word == v.word_exp, tag, "pop_word at done", pop_word, v.word_exp);
        check(nw == 0, tag, "no writes (R11)", nw, 0);
      end
      @(negedge clk);
      // R7: done one clock, busy drops after it
      check(!done && !busy, "R7", "done/busy after done cycle", {done, busy}, 2'b00);
    end

    // R8: a pop raised during a push is dropped and nothing starts later
    run_op(4'b0001, 1'b0, 16'h00A0, 16'h5566, 4'b0010, ncyc, nw, wa0, wa1, wd0, wd1, wc0, wc1);
    check(ncyc == 4 && sp_out == 16'h009E, "R8", "push with pop raised mid-transfer",
          {ncyc[15:0], sp_out}, {16'd4, 16'h009E});
    check_writes("R8", 16'h00A0, 16'h5566, ncyc, nw, wa0, wa1, wd0, wd1, wc0, wc1);
    repeat (3) begin
      @(negedge clk);
      check(!busy && !done && !mem_we, "R8", "no late transfer", {busy, done, mem_we}, 3'b000);
    end

    // R9: call beats push and pop
    run_op(4'b0111, 1'b0, 16'h00C0, 16'h789A, 4'b0000, ncyc, nw, wa0, wa1, wd0, wd1, wc0, wc1);
    check(ncyc == 6 && sp_out == 16'h00BE, "R9", "call wins over push/pop",
          {ncyc[15:0], sp_out}, {16'd6, 16'h00BE});
    @(negedge clk);
    // R9: push beats pop and return
    run_op(4'b1011, 1'b1, 16'h00D0, 16'hBEEF, 4'b0000, ncyc, nw, wa0, wa1, wd0, wd1, wc0, wc1);
    check(ncyc == 4 && sp_out == 16'h00CE, "R9", "push wins over pop/return",
          {ncyc[15:0], sp_out}, {16'd4, 16'h00CE});
    @(negedge clk);
    // R9: pop beats return; reads back the word pushed above
    run_op(4'b1010, 1'b0, 16'h00CE, 16'h0000, 4'b0000, ncyc, nw, wa0, wa1, wd0, wd1, wc0, wc1);
    check(ncyc == 3 && pop_word == 16'hBEEF, "R9", "pop wins over return",
          {ncyc[15:0], pop_word}, {16'd3, 16'hBEEF});
    @(negedge clk);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule